// File: doc/BRIEF.md
# Processor Trap Priority Selector

This block sits at the point in a processor pipeline where pending exceptions are gathered. Each cycle it receives a 36-bit vector of pending trap requests, together with the small operands the enumerated trap classes need: a register-window index, a trap-instruction number, an interrupt level and a priority for that interrupt. From these it picks the single trap to deliver and registers the 9-bit trap-type code and the 5-bit priority of that trap.

Each request bit has a fixed priority and a fixed code. The interrupt is the exception: its priority comes from an input. The smallest priority number wins. When several pending requests share the winning priority, the lowest bit index wins. The four window classes and the trap-instruction class form their code by adding an index to a base. The interrupt adds a clamped level to its base.

Top module: `trap_sel_top`

## Requirements
- R1: A synchronous reset sampled high at a clock edge sets trapValid, trapCode and trapPrio to zero after that edge.
- R2: The outputs change one clock edge after the inputs are sampled. trapValid is high after an edge exactly when at least one bit of reqVec was set at that edge.
- R3: The fixed entries, as bit:code/priority, are: 0:0x001/0, 1:0x002/1, 2:0x003/1, 3:0x004/1, 4:0x005/1, 5:0x009/2, 6:0x040/2, 7:0x00A/3, 8:0x029/4, 9:0x008/5, 10:0x011/6, 11:0x012/6, 12:0x013/6, 13:0x010/7, 14:0x020/8, 19:0x024/10, 20:0x034/10, 21:0x035/10, 22:0x036/10, 23:0x038/10, 24:0x039/10, 25:0x021/11, 26:0x022/11, 27:0x037/11, 28:0x030/12, 29:0x031/12, 30:0x032/12, 31:0x033/12, 32:0x023/14, 33:0x028/15.
- R4: Among the pending requests, the one with the numerically smallest priority is delivered.
- R5: When pending requests tie on the smallest priority, the one at the lowest reqVec bit index is delivered.
- R6: Bits 15, 16, 17 and 18 have priority 9 and code 0x080, 0x0A0, 0x0C0 and 0x0E0 plus winIdx (0 to 31). Bit 34 has priority 16 and code 0x100 plus trapNum (0 to 255).
- R7: Bit 35 is the interrupt. Its priority is irqPrio and its code is 0x041 plus irqLvl, where a level above 14 is taken as 14, so the code stays between 0x041 and 0x04F.
- R8: After an edge that sampled no pending request, trapCode and trapPrio keep the values they held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqVec | input | 36 | Pending trap requests, one bit per trap source |
| winIdx | input | 5 | Index added to the base of the window spill/fill classes |
| trapNum | input | 8 | Number added to the base of the trap-instruction class |
| irqLvl | input | 4 | Interrupt level, clamped to 14 |
| irqPrio | input | 5 | Priority assigned to the interrupt request |
| trapValid | output | 1 | A trap was selected at the last edge |
| trapCode | output | 9 | Trap-type code of the selected trap |
| trapPrio | output | 5 | Priority of the selected trap |

## Verification
The interrupt is the hardest case to reach. It sits at the highest bit index but takes its priority from an input, so it must lose a tie against every earlier bit and still win against any earlier bit whose priority is larger by one. The stimulus sets irqPrio to exactly the priority of a chosen fixed request, and then to one below it, with both requests raised at once. It does this at the extremes of priority 0 and priority 3. The interrupt level is also pushed past the clamp point, so the top of the code window is observed at the output.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;

  localparam int CODE_W     = 9;
  localparam int PRIO_W     = 5;
  localparam int NUM_REQ    = 36;
  localparam int SEL_W      = $clog2(NUM_REQ);
  localparam int WIN_SPAN   = 32;
  localparam int WIN_IDX_W  = $clog2(WIN_SPAN);
  localparam int TRAP_NUM_W = 8;
  localparam int IRQ_LVL_W  = 4;
  localparam int REQ_TRAPINST = 34;
  localparam int REQ_IRQ      = 35;

  typedef enum logic [1:0] {
    CLS_FIXED,
    CLS_WINDOW,
    CLS_TRAPNUM,
    CLS_IRQ
  } trapCls_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [PRIO_W-1:0] prio;
    trapCls_t          cls;
  } trapEnt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [SEL_W-1:0]  sel;
    logic [PRIO_W-1:0] prio;
  } selCtl_t;

  function automatic trapEnt_t mkEnt(input int code, input int prio, input trapCls_t cls);
    trapEnt_t e;
    e.code = CODE_W'(code);
    e.prio = PRIO_W'(prio);
    e.cls  = cls;
    return e;
  endfunction

  // base code, priority and class of every request bit; bit order is the tie order
  function automatic trapEnt_t trapEntry(input logic [SEL_W-1:0] sel);
    case (sel)
      6'd0:  return mkEnt('h001, 0, CLS_FIXED);
      6'd1:  return mkEnt('h002, 1, CLS_FIXED);
      6'd2:  return mkEnt('h003, 1, CLS_FIXED);
      6'd3:  return mkEnt('h004, 1, CLS_FIXED);
      6'd4:  return mkEnt('h005, 1, CLS_FIXED);
      6'd5:  return mkEnt('h009, 2, CLS_FIXED);
      6'd6:  return mkEnt('h040, 2, CLS_FIXED);
      6'd7:  return mkEnt('h00A, 3, CLS_FIXED);
      6'd8:  return mkEnt('h029, 4, CLS_FIXED);
      6'd9:  return mkEnt('h008, 5, CLS_FIXED);
      6'd10: return mkEnt('h011, 6, CLS_FIXED);
      6'd11: return mkEnt('h012, 6, CLS_FIXED);
      6'd12: return mkEnt('h013, 6, CLS_FIXED);
      6'd13: return mkEnt('h010, 7, CLS_FIXED);
      6'd14: return mkEnt('h020, 8, CLS_FIXED);
      6'd15: return mkEnt('h080, 9, CLS_WINDOW);
      6'd16: return mkEnt('h0A0, 9, CLS_WINDOW);
      6'd17: return mkEnt('h0C0, 9, CLS_WINDOW);
      6'd18: return mkEnt('h0E0, 9, CLS_WINDOW);
      6'd19: return mkEnt('h024, 10, CLS_FIXED);
      6'd20: return mkEnt('h034, 10, CLS_FIXED);
      6'd21: return mkEnt('h035, 10, CLS_FIXED);
      6'd22: return mkEnt('h036, 10, CLS_FIXED);
      6'd23: return mkEnt('h038, 10, CLS_FIXED);
      6'd24: return mkEnt('h039, 10, CLS_FIXED);
      6'd25: return mkEnt('h021, 11, CLS_FIXED);
      6'd26: return mkEnt('h022, 11, CLS_FIXED);
      6'd27: return mkEnt('h037, 11, CLS_FIXED);
      6'd28: return mkEnt('h030, 12, CLS_FIXED);
      6'd29: return mkEnt('h031, 12, CLS_FIXED);
      6'd30: return mkEnt('h032, 12, CLS_FIXED);
      6'd31: return mkEnt('h033, 12, CLS_FIXED);
      6'd32: return mkEnt('h023, 14, CLS_FIXED);
      6'd33: return mkEnt('h028, 15, CLS_FIXED);
      6'd34: return mkEnt('h100, 16, CLS_TRAPNUM);
      6'd35: return mkEnt('h041, 0, CLS_IRQ);
      default: return mkEnt(0, (1 << PRIO_W) - 1, CLS_FIXED);
    endcase
  endfunction

endpackage

// File: rtl/trap_sel_ctrl.sv
module trap_sel_ctrl
  import trap_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_REQ-1:0]   reqVec,
  input  logic [PRIO_W-1:0]    irqPrio,
  output selCtl_t              strb
);

  logic [PRIO_W-1:0] prioArr [NUM_REQ];

  // priority of each request: table constant, or the runtime interrupt priority
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_prio
    if (i == REQ_IRQ) begin : g_irq
      assign prioArr[i] = irqPrio;
    end else begin : g_fixed
      assign prioArr[i] = trapEntry(SEL_W'(i)).prio;
    end
  end

  // strict less-than keeps the earliest index on a tie
  always_comb begin
    logic              found;
    logic [PRIO_W-1:0] best;
    logic [SEL_W-1:0]  pick;
    found = 1'b0;
    best  = '1;
    pick  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqVec[i] && (!found || prioArr[i] < best)) begin
        found = 1'b1;
        best  = prioArr[i];
        pick  = SEL_W'(i);
      end
    end
    strb.load = found;
    strb.sel  = pick;
    strb.prio = best;
  end

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> reqVec[strb.sel]) else $error("winner not pending"); // R4

  AST_LOAD_IFF_REQ: assert property (@(posedge clk) disable iff (rst)
    (reqVec != '0) |-> strb.load) else $error("request dropped"); // R2

endmodule

// File: rtl/trap_sel_dp.sv
module trap_sel_dp
  import trap_sel_pkg::*;
#(
  parameter int IRQ_LVL_MAX = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  selCtl_t                strb,
  input  logic [WIN_IDX_W-1:0]   winIdx,
  input  logic [TRAP_NUM_W-1:0]  trapNum,
  input  logic [IRQ_LVL_W-1:0]   irqLvl,
  output logic                   trapValid,
  output logic [CODE_W-1:0]      trapCode,
  output logic [PRIO_W-1:0]      trapPrio
);

  localparam logic [IRQ_LVL_W-1:0] LVL_CAP = IRQ_LVL_W'(IRQ_LVL_MAX);

  trapEnt_t             ent;
  logic [IRQ_LVL_W-1:0] lvlClamped;
  logic [CODE_W-1:0]    offset;
  logic [CODE_W-1:0]    codeNext;

  assign ent        = trapEntry(strb.sel);
  assign lvlClamped = (irqLvl > LVL_CAP) ? LVL_CAP : irqLvl;

  // one adder after the table lookup, its operand picked by the class
  always_comb begin
    case (ent.cls)
      CLS_WINDOW:  offset = CODE_W'(winIdx);
      CLS_TRAPNUM: offset = CODE_W'(trapNum);
      CLS_IRQ:     offset = CODE_W'(lvlClamped);
      default:     offset = '0;
    endcase
    codeNext = ent.code + offset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trapValid <= 1'b0;
      trapCode  <= '0;
      trapPrio  <= '0;
    end else if (strb.load) begin
      trapValid <= 1'b1;
      trapCode  <= codeNext;
      trapPrio  <= strb.prio;
    end else begin
      trapValid <= 1'b0;
    end
  end

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> trapValid) else $error("valid missing"); // R2

  AST_IDLE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> !trapValid) else $error("spurious valid"); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> ($stable(trapCode) && $stable(trapPrio))) else $error("output moved"); // R8

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    trapValid |-> (trapCode != '0)) else $error("zero code"); // R3

  AST_TRAPINST_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.sel == SEL_W'(REQ_TRAPINST)) |=> trapCode[CODE_W-1]) else $error("trap window"); // R6

  AST_IRQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.sel == SEL_W'(REQ_IRQ)) |=> (trapCode >= 9'h041 && trapCode <= 9'h04F)) else $error("irq window"); // R7

endmodule

// File: rtl/trap_sel_top.sv
module trap_sel_top
  import trap_sel_pkg::*;
#(
  parameter int IRQ_LVL_MAX = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_REQ-1:0]     reqVec,
  input  logic [WIN_IDX_W-1:0]   winIdx,
  input  logic [TRAP_NUM_W-1:0]  trapNum,
  input  logic [IRQ_LVL_W-1:0]   irqLvl,
  input  logic [PRIO_W-1:0]      irqPrio,
  output logic                   trapValid,
  output logic [CODE_W-1:0]      trapCode,
  output logic [PRIO_W-1:0]      trapPrio
);

  selCtl_t strb;

  trap_sel_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqVec  (reqVec),
    .irqPrio (irqPrio),
    .strb    (strb)
  );

  trap_sel_dp #(.IRQ_LVL_MAX(IRQ_LVL_MAX)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .winIdx    (winIdx),
    .trapNum   (trapNum),
    .irqLvl    (irqLvl),
    .trapValid (trapValid),
    .trapCode  (trapCode),
    .trapPrio  (trapPrio)
  );

endmodule

// File: tb/test_trap_sel_top.sv
module test_trap_sel_top;
  import trap_sel_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NUM_REQ-1:0]    reqVec;
  logic [WIN_IDX_W-1:0]  winIdx;
  logic [TRAP_NUM_W-1:0] trapNum;
  logic [IRQ_LVL_W-1:0]  irqLvl;
  logic [PRIO_W-1:0]     irqPrio;
  logic                  trapValid;
  logic [CODE_W-1:0]     trapCode;
  logic [PRIO_W-1:0]     trapPrio;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  trap_sel_top i_trap_sel_top (
    .clk(clk), .rst(rst), .reqVec(reqVec), .winIdx(winIdx), .trapNum(trapNum),
    .irqLvl(irqLvl), .irqPrio(irqPrio), .trapValid(trapValid),
    .trapCode(trapCode), .trapPrio(trapPrio)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect3(input string tag, input int v, input int code, input int prio);
    chk(tag, "valid", int'(trapValid), v);
    chk(tag, "code", int'(trapCode), code);
    chk(tag, "prio", int'(trapPrio), prio);
  endtask

  // expected code and priority for a lone request, from the requirement tables
  function automatic int expCode(input int b);
    int t [36] = '{'h001,'h002,'h003,'h004,'h005,'h009,'h040,'h00A,'h029,'h008,
                   'h011,'h012,'h013,'h010,'h020,'h080,'h0A0,'h0C0,'h0E0,'h024,
                   'h034,'h035,'h036,'h038,'h039,'h021,'h022,'h037,'h030,'h031,
                   'h032,'h033,'h023,'h028,'h100,'h041};
    int c = t[b];
    if (b >= 15 && b <= 18) c += int'(winIdx);
    if (b == 34) c += int'(trapNum);
    if (b == 35) c += (irqLvl > 14) ? 14 : int'(irqLvl);
    return c;
  endfunction

  function automatic int expPrio(input int b);
    int p [36] = '{0,1,1,1,1,2,2,3,4,5,6,6,6,7,8,9,9,9,9,10,10,10,10,10,10,
                   11,11,11,12,12,12,12,14,15,16,0};
    if (b == 35) return int'(irqPrio);
    return p[b];
  endfunction

  task automatic t_reset();
    rst = 1'b1; reqVec = '0; winIdx = '0; trapNum = '0; irqLvl = '0; irqPrio = '0;
    step(); step();
    expect3("R1", 0, 0, 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_singles();
    winIdx = 5'd3; trapNum = 8'h5A; irqLvl = 4'd7; irqPrio = 5'd20;
    for (int b = 0; b < NUM_REQ; b++) begin
      reqVec = '0; reqVec[b] = 1'b1;
      step();
      expect3((b >= 15 && b <= 18) || b == 34 ? "R6" : (b == 35 ? "R7" : "R3"),
              1, expCode(b), expPrio(b));
    end
  endtask

  task automatic t_lowest();
    reqVec = '1; irqPrio = 5'd20; step();
    expect3("R4", 1, 'h001, 0);
    reqVec = '0; reqVec[33] = 1'b1; reqVec[32] = 1'b1; step();
    expect3("R4", 1, 'h023, 14);
    winIdx = 5'd6;
    reqVec = '0; reqVec[25] = 1'b1; reqVec[18] = 1'b1; reqVec[34] = 1'b1; step();
    expect3("R4", 1, 'h0E6, 9);
  endtask

  task automatic t_ties();
    reqVec = '0; reqVec[12] = 1'b1; reqVec[11] = 1'b1; reqVec[10] = 1'b1; step();
    expect3("R5", 1, 'h011, 6);
    reqVec = '0; reqVec[31] = 1'b1; reqVec[29] = 1'b1; step();
    expect3("R5", 1, 'h031, 12);
    reqVec = '0; reqVec[24:19] = '1; step();
    expect3("R5", 1, 'h024, 10);
    reqVec = '0; reqVec[6] = 1'b1; reqVec[5] = 1'b1; step();
    expect3("R5", 1, 'h009, 2);
  endtask

  task automatic t_irq();
    irqLvl = 4'd2;
    irqPrio = 5'd0; reqVec = '0; reqVec[35] = 1'b1; reqVec[0] = 1'b1; step();
    expect3("R5", 1, 'h001, 0);
    irqPrio = 5'd3; reqVec = '0; reqVec[35] = 1'b1; reqVec[7] = 1'b1; step();
    expect3("R5", 1, 'h00A, 3);
    irqPrio = 5'd2; step();
    expect3("R7", 1, 'h043, 2);
    irqLvl = 4'd15; irqPrio = 5'd31; reqVec = '0; reqVec[35] = 1'b1; step();
    expect3("R7", 1, 'h04F, 31);
    irqLvl = 4'd14; step();
    expect3("R7", 1, 'h04F, 31);
    irqLvl = 4'd0; step();
    expect3("R7", 1, 'h041, 31);
  endtask

  task automatic t_windows();
    winIdx = 5'd31; trapNum = 8'hFF;
    reqVec = '0; reqVec[15] = 1'b1; step();
    expect3("R6", 1, 'h09F, 9);
    reqVec = '0; reqVec[18] = 1'b1; step();
    expect3("R6", 1, 'h0FF, 9);
    reqVec = '0; reqVec[34] = 1'b1; step();
    expect3("R6", 1, 'h1FF, 16);
    trapNum = 8'h00; step();
    expect3("R6", 1, 'h100, 16);
  endtask

  task automatic t_idle();
    reqVec = '0; reqVec[32] = 1'b1; step();
    expect3("R2", 1, 'h023, 14);
    reqVec = '0; winIdx = 5'd9; trapNum = 8'h11; irqLvl = 4'd5; irqPrio = 5'd1; step();
    expect3("R8", 0, 'h023, 14);
    step();
    expect3("R8", 0, 'h023, 14);
  endtask

  task automatic t_latency();
    reqVec = '0; reqVec[9] = 1'b1;
    #2;
    chk("R2", "valid before edge", int'(trapValid), 0);
    step();
    expect3("R2", 1, 'h008, 5);
  endtask

  task automatic t_midreset();
    reqVec = '0; reqVec[1] = 1'b1; rst = 1'b1; step();
    expect3("R1", 0, 0, 0);
    rst = 1'b0; step();
    expect3("R2", 1, 'h002, 1);
    reqVec = '0; step();
  endtask

  initial begin
    t_reset();
    t_singles();
    t_lowest();
    t_ties();
    t_irq();
    t_windows();
    t_idle();
    t_latency();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule